// File: doc/BRIEF.md
# Lane Beat to Flit Group Assembler

This block sits right after the receive lanes of a point-to-point serial link. Each cycle it may be handed one lane beat: the bits captured from the active lanes at one double-data-rate sample. It packs these beats into 80-bit flits. Once eight flits are complete it hands them to the link layer as one 640-bit word on the fabric clock, flagged by a single-cycle valid pulse.

The link can run on all 20 lanes, on 10 lanes or on 5 lanes, so a flit takes 4, 8 or 16 beats. A two-bit width select picks the width at run time. The link is expected to change width only while idle. Any change of the select throws away whatever flit or group was partly built, so assembly restarts cleanly at the new width. Beats may arrive with idle cycles between them, and a new group starts on the very next beat after a group finishes.

Top module: `lane_flit_packer`

## Requirements
- R1: While reset is asserted, and after it is released, `grp_valid` is 0 and `grp_data` is all zero until the first group completes.
- R2: Width code 0 (full) uses `beat_data[19:0]`; 4 beats make one flit, and beat k of a flit lands in flit bits [20k+19:20k].
- R3: Width code 1 (half) uses `beat_data[9:0]` and ignores lanes 19..10; 8 beats make one flit, and beat k lands in flit bits [10k+9:10k].
- R4: Width codes 2 and 3 (quarter) use `beat_data[4:0]` and ignore lanes 19..5; 16 beats make one flit, and beat k lands in flit bits [5k+4:5k].
- R5: Flit f of a group (f = 0..7, in arrival order) occupies `grp_data[80f+79:80f]`. `grp_valid` is high in the cycle right after the clock edge that samples the final beat of flit 7.
- R6: `grp_valid` lasts exactly one cycle, and `grp_data` keeps its value until the next group completes.
- R7: A cycle with `beat_valid` low has no effect, whatever `beat_data` holds, and is never followed by a `grp_valid` pulse.
- R8: The beat sampled in the cycle after a group completes is beat 0 of flit 0 of the next group, so back-to-back beats produce groups with no dead cycles.
- R9: A cycle in which `width_mode` differs from its value in the previous cycle discards any partial flit and group. The beat offered in that same cycle is dropped, including a beat that would have completed a group, so no `grp_valid` follows that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_mode | input | 2 | Link width: 0 full, 1 half, 2 or 3 quarter |
| beat_valid | input | 1 | Qualifies `beat_data` this cycle |
| beat_data | input | 20 | One lane beat; lane 0 is bit 0 |
| grp_valid | output | 1 | One-cycle pulse: `grp_data` holds a new group |
| grp_data | output | 640 | Eight flits, flit 0 in the lowest 80 bits |

## Verification
Two functions can fall in the same cycle: completing a group and clearing state on a width change. The bench provokes this by offering the final beat of a half-width group while moving the select to full width. It judges the result by requiring that no pulse follows that cycle and that the next full-width group is built only from beats sent after the change. A second overlap is a group completing in the same cycle that the next group begins. Back-to-back groups with no idle cycles check this, by requiring the second pulse to land exactly on its own last beat with the correct contents.

// File: rtl/lfp_pkg.sv
package lfp_pkg;

    typedef enum logic [1:0] {
        LFP_FULL    = 2'd0,
        LFP_HALF    = 2'd1,
        LFP_QUARTER = 2'd2,
        LFP_QTR_ALT = 2'd3
    } lfp_width_e;

endpackage

// File: rtl/lfp_flit_builder.sv
module lfp_flit_builder
    import lfp_pkg::*;
#(
    parameter int LANES  = 20,
    parameter int FLIT_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  lfp_width_e        mode,
    input  logic              beat_valid,
    input  logic [LANES-1:0]  beat_data,
    output logic              flit_valid,
    output logic [FLIT_W-1:0] flit_data
);
    localparam int HALF_L  = LANES / 2;
    localparam int QTR_L   = LANES / 4;
    localparam int BEATS_F = FLIT_W / LANES;
    localparam int BEATS_H = FLIT_W / HALF_L;
    localparam int BEATS_Q = FLIT_W / QTR_L;
    localparam int CW      = $clog2(BEATS_Q);

    typedef struct packed {
        logic [FLIT_W-1:0] acc;
        logic [CW-1:0]     idx;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0]     last_idx;
    logic [FLIT_W-1:0] merged;
    logic              take;

    always_comb begin
        st_d     = st_q;
        merged   = st_q.acc;
        take     = beat_valid && !clr;
        case (mode)
            LFP_FULL: begin
                last_idx = CW'(BEATS_F - 1);
                merged[st_q.idx*LANES +: LANES] = beat_data;
            end
            LFP_HALF: begin
                last_idx = CW'(BEATS_H - 1);
                merged[st_q.idx*HALF_L +: HALF_L] = beat_data[HALF_L-1:0];
            end
            default: begin
                last_idx = CW'(BEATS_Q - 1);
                merged[st_q.idx*QTR_L +: QTR_L] = beat_data[QTR_L-1:0];
            end
        endcase
        flit_valid = take && (st_q.idx == last_idx);
        flit_data  = merged;
        if (clr) begin
            st_d.idx = '0;
        end else if (take) begin
            st_d.acc = merged;
            st_d.idx = (st_q.idx == last_idx) ? '0 : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2 R3 R4: the beat position never runs past the last beat of the mode
    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> st_q.idx <= last_idx);

    // R9: a clear returns the builder to beat 0
    p_clear_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.idx == '0);

endmodule

// File: rtl/lfp_group_collector.sv
module lfp_group_collector #(
    parameter int FLIT_W      = 80,
    parameter int GROUP_FLITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          flit_valid,
    input  logic [FLIT_W-1:0]             flit_data,
    output logic                          grp_valid,
    output logic [FLIT_W*GROUP_FLITS-1:0] grp_data
);
    localparam int GW = FLIT_W * GROUP_FLITS;
    localparam int SW = $clog2(GROUP_FLITS);

    typedef struct packed {
        logic [GW-1:0] gbuf;
        logic [SW-1:0] slot;
        logic [GW-1:0] out_data;
        logic          out_valid;
    } st_t;

    st_t st_d, st_q;
    logic [GW-1:0] merged;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        merged         = st_q.gbuf;
        merged[st_q.slot*FLIT_W +: FLIT_W] = flit_data;
        if (clr) begin
            st_d.slot = '0;
        end else if (flit_valid) begin
            st_d.gbuf = merged;
            if (st_q.slot == SW'(GROUP_FLITS - 1)) begin
                st_d.slot      = '0;
                st_d.out_data  = merged;
                st_d.out_valid = 1'b1;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grp_valid = st_q.out_valid;
    assign grp_data  = st_q.out_data;

    // R6: the pulse never lasts two cycles
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> !grp_valid);

    // R6: data only moves together with a pulse
    p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |-> $stable(grp_data));

    // R5: a group is released only by a completed flit
    p_pulse_needs_flit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> $past(flit_valid));

endmodule

// File: rtl/lane_flit_packer.sv
module lane_flit_packer
    import lfp_pkg::*;
#(
    parameter int LANES       = 20,
    parameter int FLIT_W      = 80,
    parameter int GROUP_FLITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    width_mode,
    input  logic                          beat_valid,
    input  logic [LANES-1:0]              beat_data,
    output logic                          grp_valid,
    output logic [FLIT_W*GROUP_FLITS-1:0] grp_data
);
    typedef struct packed {
        logic [1:0] mode;
    } st_t;

    st_t st_d, st_q;
    logic              clr;
    logic              flit_valid;
    logic [FLIT_W-1:0] flit_data;

    always_comb begin
        st_d      = st_q;
        clr       = (width_mode != st_q.mode);
        st_d.mode = width_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: LFP_FULL};
        else        st_q <= st_d;
    end

    lfp_flit_builder #(
        .LANES  (LANES),
        .FLIT_W (FLIT_W)
    ) u_builder (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .mode       (lfp_width_e'(width_mode)),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .flit_valid (flit_valid),
        .flit_data  (flit_data)
    );

    lfp_group_collector #(
        .FLIT_W      (FLIT_W),
        .GROUP_FLITS (GROUP_FLITS)
    ) u_collector (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .flit_valid (flit_valid),
        .flit_data  (flit_data),
        .grp_valid  (grp_valid),
        .grp_data   (grp_data)
    );

    // R9: a width change never lets a group out
    p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !grp_valid);

    // R7: an idle cycle never completes a group
    p_idle_no_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> !grp_valid);

endmodule

// File: tb/lane_flit_packer_test.sv
`timescale 1ns/1ps
module lane_flit_packer_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   width_mode;
    logic         beat_valid;
    logic [19:0]  beat_data;
    logic         grp_valid;
    logic [639:0] grp_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    int cur_mode = 0;
    logic [19:0]  beats [0:127];
    logic [639:0] last_exp;

    always #10 clk = ~clk;

    lane_flit_packer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .width_mode (width_mode),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .grp_valid  (grp_valid),
        .grp_data   (grp_data)
    );

    function automatic int lanes_of(input int m);
        if (m == 0) return 20;
        if (m == 1) return 10;
        return 5;
    endfunction

    // Beat i of the group, counted across flits, fills group bits [i*w +: w]
    function automatic logic [639:0] exp_group(input int w, input int n);
        logic [639:0] g = '0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < w; b++)
                g[i*w + b] = beats[i][b];
        return g;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s grp_valid actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_vec(input string req, input logic [639:0] act, input logic [639:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s grp_data actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_cycle(input string req);
        @(negedge clk);
        beat_valid = 1'b0;
        beat_data  = 20'($urandom);
        width_mode = 2'(cur_mode);
        @(posedge clk); #1;
        check_bit(req, grp_valid, 1'b0);
    endtask

    task automatic change_mode(input int m, input bit with_beat);
        @(negedge clk);
        cur_mode   = m;
        width_mode = 2'(m);
        beat_valid = with_beat;
        beat_data  = 20'($urandom);
        @(posedge clk); #1;
        check_bit("R9 change", grp_valid, 1'b0);
    endtask

    task automatic send_raw(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            beat_valid = 1'b1;
            beat_data  = 20'($urandom);
            width_mode = 2'(cur_mode);
            @(posedge clk); #1;
            check_bit("R9 partial", grp_valid, 1'b0);
        end
    endtask

    task automatic run_group(input int gap_pct, input string req);
        int w = lanes_of(cur_mode);
        int n = 640 / w;
        for (int i = 0; i < n; i++) beats[i] = 20'($urandom);
        last_exp = exp_group(w, n);
        for (int i = 0; i < n; i++) begin
            while (int'($urandom % 100) < gap_pct) idle_cycle("R7 gap");
            @(negedge clk);
            beat_valid = 1'b1;
            beat_data  = beats[i];
            width_mode = 2'(cur_mode);
            @(posedge clk); #1;
            if (i == n - 1) check_bit({req, " R5 pulse"}, grp_valid, 1'b1);
            else if (grp_valid !== 1'b0) check_bit({req, " early"}, grp_valid, 1'b0);
        end
        check_vec(req, grp_data, last_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; width_mode = 2'd0; beat_valid = 1'b0; beat_data = '0;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R1 in reset", grp_valid, 1'b0);
        check_vec("R1 in reset", grp_data, '0);
        @(negedge clk); rst_n = 1'b1;
        idle_cycle("R1 after reset");
        check_vec("R1 after reset", grp_data, '0);

        // R2 R5 full width, then R8 back-to-back second group
        run_group(0, "R2 full");
        run_group(0, "R8 back-to-back");
        idle_cycle("R6 pulse ends");
        check_vec("R6 hold", grp_data, last_exp);
        idle_cycle("R6 pulse stays low");
        check_vec("R6 hold 2", grp_data, last_exp);

        // R7 idle cycles with junk data in between
        run_group(30, "R7 gaps full");

        // R3 half width, upper lanes carry junk
        change_mode(1, 1'b1);
        run_group(20, "R3 half");
        run_group(0, "R3 half b2b");

        // R4 quarter width under both codes
        change_mode(2, 1'b0);
        run_group(10, "R4 quarter code2");
        change_mode(3, 1'b1);
        run_group(0, "R4 quarter code3");

        // R9 partial state discarded across a change
        change_mode(0, 1'b1);
        send_raw(20);
        change_mode(1, 1'b1);
        run_group(0, "R9 after discard");

        // R9 width change in the cycle of the completing beat
        send_raw(63);
        @(negedge clk);
        beat_valid = 1'b1; beat_data = 20'($urandom); width_mode = 2'd0; cur_mode = 0;
        @(posedge clk); #1;
        check_bit("R9 collision", grp_valid, 1'b0);
        idle_cycle("R9 collision after");
        run_group(0, "R9 fresh full after collision");

        // random mixes
        for (int k = 0; k < 10; k++) begin
            int m = int'($urandom % 4);
            if (m == cur_mode) m = (m + 1) % 4;
            change_mode(m, 1'($urandom));
            run_group(int'($urandom % 40), "R2 R3 R4 random");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule